// File: doc/BRIEF.md
# Endpoint loopback test command engine

This block is a register-mapped self-test function for a bus endpoint. A host programs a handful of word registers (a scratch word, buffer addresses, a byte count and an interrupt selection) and then writes a one-hot command word. The engine then does one job: it raises an interrupt of a given kind, reads a buffer out of host memory while folding it into an XOR checksum, fills a host buffer with a counting pattern, or copies one host buffer to another word by word.

Memory traffic leaves through a plain request/response master port: one outstanding 32-bit access, held until the response arrives. When a job ends, the engine records success, failure and bad-address flags in a status word. It then sends a one-cycle interrupt request that carries a kind and a vector number, provided the number fits the kind. The command register reads back non-zero while a job runs and returns to zero when the job is over, so the host can poll it.

Top module: `lbk_engine`

## Requirements
- R1: Registers sit at word offsets 0 scratch, 1 command, 2 status, 3 source address, 4 destination address, 5 byte count, 6 interrupt kind (bits 1:0), 7 interrupt number and 8 checksum. The scratch word stores any 32-bit value written to it and returns it on read.
- R2: A command write is accepted only when the command register reads zero and exactly one of bits 5:0 is set. An accepted command clears status bits 8:0 and stays readable until the job ends, after which the register reads zero. Any other command write changes neither the command register nor the status register and starts no traffic.
- R3: Command bit 0, 1 and 2 each raise an interrupt of kind 0 (legacy), 1 (MSI) or 2 (MSI-X) respectively. The number comes from the interrupt number register, the interrupt kind register is not used, and no memory traffic takes place.
- R4: An interrupt goes out only if its number is legal for its kind: 0 for legacy, 1 to 32 for MSI, 1 to 2048 for MSI-X. Kind 3 is never legal. An illegal number suppresses the pulse and leaves status bit 6 clear.
- R5: Command bit 3 reads count/4 words (count rounded down) upward from the source address. It XORs each word into the checksum register, which is cleared when the command is accepted. It then sets status bit 0.
- R6: Command bit 4 writes count/4 words upward from the destination address, with word k holding the value k, and then sets status bit 2.
- R7: Command bit 5 copies count/4 words by reading source word k and then writing that value to destination word k, for k ascending, and then sets status bit 4. A count below 4 in any transfer command moves nothing and reports success.
- R8: An address is invalid if it is zero or if bits 1:0 are not 00. An invalid source (read, copy) sets status bit 7 and an invalid destination (write, copy) sets bit 8. In either case the command's fail bit is set (1 read, 3 write, 5 copy), no memory access is made and the completion interrupt is still attempted.
- R9: A response with mem_rsp_err high ends the transfer at that access. It sets the command's fail bit instead of its success bit, and the success and fail bits of one command are never both set.
- R10: After a read, write or copy, the engine attempts a completion interrupt whose kind comes from the interrupt kind register. A sent interrupt is a single-cycle irq_valid pulse, and status bit 6 reads one from the cycle of the pulse until the next accepted command.
- R11: mem_req holds its address, write flag and write data unchanged until a rising edge at which mem_rsp_valid is high. Every address it presents is a multiple of 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| mem_req | output | 1 | Memory access request, held until response |
| mem_we | output | 1 | 1 for a write access, 0 for a read |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Response for the current request |
| mem_rsp_err | input | 1 | Response reports an error |
| mem_rsp_rdata | input | 32 | Read data of the response |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_type | output | 2 | Interrupt kind: 0 legacy, 1 MSI, 2 MSI-X |
| irq_num | output | 12 | Interrupt vector number |

## Verification
The bench builds the engine with its default limits of 32 MSI vectors and 2048 MSI-X vectors. Both edges of each legal range can therefore be tested directly: 32 and 2048 are accepted, while 33, 2049 and a zero MSI-X number are dropped. With these limits the vector output is 12 bits wide, so a number such as 2049 cannot alias onto a legal value through truncation. A reference memory model answers every access one cycle after it appears, which lets the bench inject an error response at any chosen address to reach both a failing read and a failing write inside a copy.

// File: rtl/lbk_pkg.sv
package lbk_pkg;

    localparam int DATA_W   = 32;
    localparam int REG_AW   = 4;
    localparam int CMD_W    = 6;
    localparam int NUM_STAT = 9;

    // register word offsets
    localparam logic [REG_AW-1:0] RG_SCRATCH = 4'd0;
    localparam logic [REG_AW-1:0] RG_CMD     = 4'd1;
    localparam logic [REG_AW-1:0] RG_STAT    = 4'd2;
    localparam logic [REG_AW-1:0] RG_SRC     = 4'd3;
    localparam logic [REG_AW-1:0] RG_DST     = 4'd4;
    localparam logic [REG_AW-1:0] RG_COUNT   = 4'd5;
    localparam logic [REG_AW-1:0] RG_IKIND   = 4'd6;
    localparam logic [REG_AW-1:0] RG_INUM    = 4'd7;
    localparam logic [REG_AW-1:0] RG_SUM     = 4'd8;

    // command bits
    localparam int CB_LEG  = 0;
    localparam int CB_MSI  = 1;
    localparam int CB_MSIX = 2;
    localparam int CB_RD   = 3;
    localparam int CB_WR   = 4;
    localparam int CB_CP   = 5;

    // status bits
    localparam int ST_RD_OK   = 0;
    localparam int ST_RD_FAIL = 1;
    localparam int ST_WR_OK   = 2;
    localparam int ST_WR_FAIL = 3;
    localparam int ST_CP_OK   = 4;
    localparam int ST_CP_FAIL = 5;
    localparam int ST_IRQ     = 6;
    localparam int ST_SRC_BAD = 7;
    localparam int ST_DST_BAD = 8;

    typedef enum logic [1:0] {
        IK_LEGACY = 2'd0,
        IK_MSI    = 2'd1,
        IK_MSIX   = 2'd2,
        IK_NONE   = 2'd3
    } irq_kind_e;

    typedef enum logic [1:0] {
        OP_RAISE, OP_READ, OP_WRITE, OP_COPY
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE, S_CHECK, S_RD, S_WR, S_IRQ, S_DONE
    } state_e;

    typedef struct packed {
        logic              we;
        logic [DATA_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } mem_cmd_t;

    typedef struct packed {
        logic [DATA_W-1:0] src;
        logic [DATA_W-1:0] dst;
        logic [DATA_W-1:0] count;
        irq_kind_e         kind;
        logic [DATA_W-1:0] num;
    } cfg_t;

    function automatic logic addr_ok(input logic [DATA_W-1:0] a);
        return (a != '0) && (a[1:0] == 2'b00);
    endfunction

    function automatic logic num_ok(input irq_kind_e k, input logic [DATA_W-1:0] n,
                                    input int msi_max, input int msix_max);
        case (k)
            IK_LEGACY: return n == '0;
            IK_MSI:    return (n != '0) && (n <= DATA_W'(msi_max));
            IK_MSIX:   return (n != '0) && (n <= DATA_W'(msix_max));
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/lbk_regs.sv
module lbk_regs
    import lbk_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_we,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic [CMD_W-1:0]    cmd_q,
    input  logic [NUM_STAT-1:0] stat_q,
    input  logic [DATA_W-1:0]   sum_q,
    output cfg_t                cfg,
    output logic                cmd_wr,
    output logic [CMD_W-1:0]    cmd_wdata
);
    logic [DATA_W-1:0] scratch;

    assign cmd_wr    = reg_we && (reg_addr == RG_CMD);
    assign cmd_wdata = reg_wdata[CMD_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            scratch   <= '0;
            cfg.src   <= '0;
            cfg.dst   <= '0;
            cfg.count <= '0;
            cfg.kind  <= IK_LEGACY;
            cfg.num   <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                RG_SCRATCH: scratch   <= reg_wdata;
                RG_SRC:     cfg.src   <= reg_wdata;
                RG_DST:     cfg.dst   <= reg_wdata;
                RG_COUNT:   cfg.count <= reg_wdata;
                RG_IKIND:   cfg.kind  <= irq_kind_e'(reg_wdata[1:0]);
                RG_INUM:    cfg.num   <= reg_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (reg_addr)
            RG_SCRATCH: reg_rdata = scratch;
            RG_CMD:     reg_rdata = {{(DATA_W-CMD_W){1'b0}}, cmd_q};
            RG_STAT:    reg_rdata = {{(DATA_W-NUM_STAT){1'b0}}, stat_q};
            RG_SRC:     reg_rdata = cfg.src;
            RG_DST:     reg_rdata = cfg.dst;
            RG_COUNT:   reg_rdata = cfg.count;
            RG_IKIND:   reg_rdata = {{(DATA_W-2){1'b0}}, cfg.kind};
            RG_INUM:    reg_rdata = cfg.num;
            RG_SUM:     reg_rdata = sum_q;
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/lbk_seq.sv
module lbk_seq
    import lbk_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_wr,
    input  logic [CMD_W-1:0]    cmd_wdata,
    input  cfg_t                cfg,
    output logic                mem_req,
    output mem_cmd_t            mem_cmd,
    input  logic                mem_rsp_valid,
    input  logic                mem_rsp_err,
    input  logic [DATA_W-1:0]   mem_rsp_rdata,
    output logic                fire,
    output irq_kind_e           fire_kind,
    input  logic                irq_accept,
    output logic [CMD_W-1:0]    cmd_q,
    output logic [NUM_STAT-1:0] stat_q,
    output logic [DATA_W-1:0]   sum_q
);
    state_e             st;
    op_e                op;
    irq_kind_e          rk;
    logic [DATA_W-1:0]  idx;
    logic [DATA_W-1:0]  nw;
    logic [DATA_W-1:0]  hold;
    logic [DATA_W-1:0]  off;
    logic               last;
    logic               start;
    logic               need_src, need_dst;
    logic [NUM_STAT-1:0] ok_m, fail_m, bad_m;

    assign start = cmd_wr && (st == S_IDLE) && $onehot(cmd_wdata);
    assign last  = (idx == nw - 1'b1);
    assign off   = idx << 2;

    // success, failure and address-check masks of the running job
    always_comb begin
        ok_m     = '0;
        fail_m   = '0;
        need_src = 1'b0;
        need_dst = 1'b0;
        case (op)
            OP_READ:  begin ok_m[ST_RD_OK] = 1'b1; fail_m[ST_RD_FAIL] = 1'b1; need_src = 1'b1; end
            OP_WRITE: begin ok_m[ST_WR_OK] = 1'b1; fail_m[ST_WR_FAIL] = 1'b1; need_dst = 1'b1; end
            OP_COPY:  begin
                ok_m[ST_CP_OK]   = 1'b1;
                fail_m[ST_CP_FAIL] = 1'b1;
                need_src = 1'b1;
                need_dst = 1'b1;
            end
            default: ;
        endcase
        bad_m = '0;
        bad_m[ST_SRC_BAD] = need_src && !addr_ok(cfg.src);
        bad_m[ST_DST_BAD] = need_dst && !addr_ok(cfg.dst);
    end

    always_comb begin
        mem_req      = (st == S_RD) || (st == S_WR);
        mem_cmd.we   = (st == S_WR);
        mem_cmd.addr = (st == S_WR) ? cfg.dst + off : cfg.src + off;
        mem_cmd.data = (op == OP_WRITE) ? idx : hold;
    end

    assign fire      = (st == S_IRQ);
    assign fire_kind = rk;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            op     <= OP_RAISE;
            rk     <= IK_LEGACY;
            idx    <= '0;
            nw     <= '0;
            hold   <= '0;
            cmd_q  <= '0;
            stat_q <= '0;
            sum_q  <= '0;
        end else begin
            case (st)
                S_IDLE: if (start) begin
                    cmd_q  <= cmd_wdata;
                    stat_q <= '0;
                    idx    <= '0;
                    nw     <= cfg.count >> 2;
                    rk     <= cfg.kind;
                    st     <= S_CHECK;
                    if (cmd_wdata[CB_LEG]) begin
                        op <= OP_RAISE; rk <= IK_LEGACY;
                    end else if (cmd_wdata[CB_MSI]) begin
                        op <= OP_RAISE; rk <= IK_MSI;
                    end else if (cmd_wdata[CB_MSIX]) begin
                        op <= OP_RAISE; rk <= IK_MSIX;
                    end else if (cmd_wdata[CB_RD]) begin
                        op <= OP_READ; sum_q <= '0;
                    end else if (cmd_wdata[CB_WR]) begin
                        op <= OP_WRITE;
                    end else begin
                        op <= OP_COPY;
                    end
                end
                S_CHECK: begin
                    if (op == OP_RAISE) begin
                        st <= S_IRQ;
                    end else if (|bad_m) begin
                        stat_q <= stat_q | bad_m | fail_m;
                        st     <= S_IRQ;
                    end else if (nw == '0) begin
                        stat_q <= stat_q | ok_m;
                        st     <= S_IRQ;
                    end else begin
                        st <= (op == OP_WRITE) ? S_WR : S_RD;
                    end
                end
                S_RD: if (mem_rsp_valid) begin
                    if (mem_rsp_err) begin
                        stat_q <= stat_q | fail_m;
                        st     <= S_IRQ;
                    end else if (op == OP_READ) begin
                        sum_q <= sum_q ^ mem_rsp_rdata;
                        if (last) begin
                            stat_q <= stat_q | ok_m;
                            st     <= S_IRQ;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end else begin
                        hold <= mem_rsp_rdata;
                        st   <= S_WR;
                    end
                end
                S_WR: if (mem_rsp_valid) begin
                    if (mem_rsp_err) begin
                        stat_q <= stat_q | fail_m;
                        st     <= S_IRQ;
                    end else if (last) begin
                        stat_q <= stat_q | ok_m;
                        st     <= S_IRQ;
                    end else begin
                        idx <= idx + 1'b1;
                        st  <= (op == OP_COPY) ? S_RD : S_WR;
                    end
                end
                S_IRQ: begin
                    if (irq_accept) stat_q[ST_IRQ] <= 1'b1;
                    st <= S_DONE;
                end
                S_DONE: begin
                    cmd_q <= '0;
                    st    <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lbk_irq.sv
module lbk_irq
    import lbk_pkg::*;
#(
    parameter int MSI_MAX  = 32,
    parameter int MSIX_MAX = 2048,
    parameter int NUM_W    = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  irq_kind_e         kind,
    input  logic [DATA_W-1:0] num,
    output logic              accept,
    output logic              irq_valid,
    output logic [1:0]        irq_type,
    output logic [NUM_W-1:0]  irq_num
);
    assign accept = fire && num_ok(kind, num, MSI_MAX, MSIX_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_valid <= 1'b0;
            irq_type  <= 2'd0;
            irq_num   <= '0;
        end else begin
            irq_valid <= accept;
            if (accept) begin
                irq_type <= kind;
                irq_num  <= num[NUM_W-1:0];
            end
        end
    end
endmodule

// File: rtl/lbk_engine.sv
module lbk_engine
    import lbk_pkg::*;
#(
    parameter int MSI_MAX  = 32,
    parameter int MSIX_MAX = 2048,
    localparam int NUM_W   = $clog2(MSIX_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_rsp_valid,
    input  logic              mem_rsp_err,
    input  logic [DATA_W-1:0] mem_rsp_rdata,
    output logic              irq_valid,
    output logic [1:0]        irq_type,
    output logic [NUM_W-1:0]  irq_num
);
    cfg_t                cfg;
    mem_cmd_t            mcmd;
    logic                cmd_wr;
    logic [CMD_W-1:0]    cmd_wdata;
    logic [CMD_W-1:0]    cmd_now;
    logic [NUM_STAT-1:0] stat_now;
    logic [DATA_W-1:0]   sum_now;
    logic                fire, accept;
    irq_kind_e           fire_kind;

    lbk_regs u_regs (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cmd_q(cmd_now), .stat_q(stat_now), .sum_q(sum_now),
        .cfg(cfg), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata)
    );

    lbk_seq u_seq (
        .clk(clk), .rst(rst),
        .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .cfg(cfg),
        .mem_req(mem_req), .mem_cmd(mcmd),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err), .mem_rsp_rdata(mem_rsp_rdata),
        .fire(fire), .fire_kind(fire_kind), .irq_accept(accept),
        .cmd_q(cmd_now), .stat_q(stat_now), .sum_q(sum_now)
    );

    lbk_irq #(.MSI_MAX(MSI_MAX), .MSIX_MAX(MSIX_MAX), .NUM_W(NUM_W)) u_irq (
        .clk(clk), .rst(rst),
        .fire(fire), .kind(fire_kind), .num(cfg.num), .accept(accept),
        .irq_valid(irq_valid), .irq_type(irq_type), .irq_num(irq_num)
    );

    assign mem_we    = mcmd.we;
    assign mem_addr  = mcmd.addr;
    assign mem_wdata = mcmd.data;
endmodule

// File: rtl/lbk_engine_chk.sv
module lbk_engine_chk
    import lbk_pkg::*;
#(
    parameter int MSI_MAX  = 32,
    parameter int MSIX_MAX = 2048,
    parameter int NUM_W    = 12
) (
    input logic                clk,
    input logic                rst,
    input logic                mem_req,
    input logic                mem_we,
    input logic [DATA_W-1:0]   mem_addr,
    input logic [DATA_W-1:0]   mem_wdata,
    input logic                mem_rsp_valid,
    input logic                irq_valid,
    input logic [1:0]          irq_type,
    input logic [NUM_W-1:0]    irq_num,
    input logic [CMD_W-1:0]    cmd_w,
    input logic [NUM_STAT-1:0] stat_w
);
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        irq_valid |=> !irq_valid); // R10

    AST_IRQ_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> stat_w[ST_IRQ]); // R10

    AST_IRQ_LEGAL: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> ((irq_type == 2'd0 && irq_num == '0) ||
                       (irq_type == 2'd1 && irq_num != '0 && irq_num <= NUM_W'(MSI_MAX)) ||
                       (irq_type == 2'd2 && irq_num != '0 && irq_num <= NUM_W'(MSIX_MAX)))); // R4

    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rsp_valid) |=> (mem_req && $stable(mem_addr) &&
                                         $stable(mem_we) && $stable(mem_wdata))); // R11

    AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[1:0] == 2'b00)); // R11

    AST_REQ_BUSY: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (cmd_w != '0)); // R2

    AST_OUTCOME_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(stat_w[ST_RD_OK] && stat_w[ST_RD_FAIL]) &&
        !(stat_w[ST_WR_OK] && stat_w[ST_WR_FAIL]) &&
        !(stat_w[ST_CP_OK] && stat_w[ST_CP_FAIL])); // R9
endmodule

bind lbk_engine lbk_engine_chk #(.MSI_MAX(MSI_MAX), .MSIX_MAX(MSIX_MAX), .NUM_W(NUM_W)) u_chk (
    .clk(clk), .rst(rst),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rsp_valid(mem_rsp_valid),
    .irq_valid(irq_valid), .irq_type(irq_type), .irq_num(irq_num),
    .cmd_w(cmd_now), .stat_w(stat_now)
);

// File: tb/lbk_engine_bench.sv
module lbk_engine_bench;
    import lbk_pkg::*;

    localparam int CLK_P    = 10;
    localparam int MSI_MAX  = 32;
    localparam int MSIX_MAX = 2048;
    localparam int NUM_W    = $clog2(MSIX_MAX + 1);

    logic              clk, rst;
    logic              reg_we;
    logic [3:0]        reg_addr;
    logic [31:0]       reg_wdata, reg_rdata;
    logic              mem_req, mem_we;
    logic [31:0]       mem_addr, mem_wdata;
    logic              mem_rsp_valid, mem_rsp_err;
    logic [31:0]       mem_rsp_rdata;
    logic              irq_valid;
    logic [1:0]        irq_type;
    logic [NUM_W-1:0]  irq_num;

    lbk_engine #(.MSI_MAX(MSI_MAX), .MSIX_MAX(MSIX_MAX)) u_lbk_engine (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err), .mem_rsp_rdata(mem_rsp_rdata),
        .irq_valid(irq_valid), .irq_type(irq_type), .irq_num(irq_num)
    );

    typedef struct {
        bit        we;
        bit [31:0] addr;
        bit [31:0] data;
        string     tag;
    } mexp_t;

    typedef struct {
        bit [1:0]  kind;
        bit [31:0] num;
        string     tag;
    } iexp_t;

    mexp_t     mq[$];
    iexp_t     iq[$];
    int        n_chk = 0;
    int        n_bad = 0;
    bit [31:0] mem [256];
    bit [31:0] err_addr = 32'hFFFF_FFF0;
    bit [31:0] b_src, b_dst, b_cnt, b_num;
    int        b_kind;

    initial begin
        clk = 1'b0;
        forever #(CLK_P/2) clk = ~clk;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report_and_end();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    function automatic int widx(input bit [31:0] a);
        return int'((a >> 2) & 32'hFF);
    endfunction

    function automatic bit legal(input int k, input bit [31:0] n);
        case (k)
            0:       return n == 0;
            1:       return n >= 1 && n <= MSI_MAX;
            2:       return n >= 1 && n <= MSIX_MAX;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit aok(input bit [31:0] a);
        return a != 0 && a[1:0] == 2'b00;
    endfunction

    // memory responder and scoreboard monitor for the master port
    initial begin
        mem_rsp_valid = 1'b0;
        mem_rsp_err   = 1'b0;
        mem_rsp_rdata = '0;
        forever begin
            @(negedge clk);
            if (mem_rsp_valid) begin
                mem_rsp_valid = 1'b0;
                mem_rsp_err   = 1'b0;
            end else if (mem_req === 1'b1) begin
                if (mq.size() == 0) begin
                    check(1'b0, "R11 unexpected memory request", mem_addr, 32'h0);
                end else begin
                    mexp_t e;
                    e = mq.pop_front();
                    check(mem_addr == e.addr && mem_we == e.we, {e.tag, " address"}, mem_addr, e.addr);
                    if (e.we) check(mem_wdata == e.data, {e.tag, " data"}, mem_wdata, e.data);
                end
                mem_rsp_err   = (mem_addr == err_addr);
                mem_rsp_rdata = mem[widx(mem_addr)];
                if (mem_we && mem_addr != err_addr) mem[widx(mem_addr)] = mem_wdata;
                mem_rsp_valid = 1'b1;
            end
        end
    end

    // interrupt monitor
    initial begin
        forever begin
            @(negedge clk);
            if (irq_valid === 1'b1) begin
                if (iq.size() == 0) begin
                    check(1'b0, "R4 unexpected interrupt", {30'b0, irq_type}, 32'h0);
                end else begin
                    iexp_t e;
                    e = iq.pop_front();
                    check(irq_type == e.kind, {e.tag, " kind"}, {30'b0, irq_type}, {30'b0, e.kind});
                    check(32'(irq_num) == e.num, {e.tag, " number"}, 32'(irq_num), e.num);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 1, 0);
        report_and_end();
    end

    task automatic reg_wr(input bit [3:0] a, input bit [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input bit [3:0] a, output bit [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic set_cfg(input bit [31:0] s, input bit [31:0] dd, input bit [31:0] c,
                           input int k, input bit [31:0] n);
        b_src = s; b_dst = dd; b_cnt = c; b_kind = k; b_num = n;
        reg_wr(RG_SRC, s);
        reg_wr(RG_DST, dd);
        reg_wr(RG_COUNT, c);
        reg_wr(RG_IKIND, 32'(k));
        reg_wr(RG_INUM, n);
    endtask

    task automatic push_m(input bit we, input bit [31:0] a, input bit [31:0] d, input string tag);
        mexp_t e;
        e.we = we; e.addr = a; e.data = d; e.tag = tag;
        mq.push_back(e);
    endtask

    task automatic push_i(input int k, input bit [31:0] n, input string tag);
        iexp_t e;
        e.kind = 2'(k); e.num = n; e.tag = tag;
        iq.push_back(e);
    endtask

    // driver: predict traffic, interrupt and status, run the command, compare
    task automatic run_op(input bit [5:0] cmd, input string tag, input bit poke);
        bit [31:0] st = 0;
        bit [31:0] sum = 0;
        bit [31:0] v;
        int        nw = int'(b_cnt >> 2);
        bit        okf = 1'b1;
        bit [31:0] a;
        bit [31:0] w;
        bit        done = 1'b0;
        if (cmd[2:0] != 0) begin
            int k = cmd[0] ? 0 : (cmd[1] ? 1 : 2);
            if (legal(k, b_num)) begin
                push_i(k, b_num, {tag, " R3 raise"});
                st[ST_IRQ] = 1'b1;
            end
        end else begin
            if (cmd[CB_RD]) begin
                if (!aok(b_src)) begin
                    st[ST_SRC_BAD] = 1'b1; st[ST_RD_FAIL] = 1'b1;
                end else begin
                    for (int i = 0; i < nw && okf; i++) begin
                        a = b_src + 32'(4 * i);
                        push_m(1'b0, a, 0, {tag, " R5 read"});
                        if (a == err_addr) okf = 1'b0;
                        else sum ^= mem[widx(a)];
                    end
                    if (okf) st[ST_RD_OK] = 1'b1; else st[ST_RD_FAIL] = 1'b1;
                end
            end else if (cmd[CB_WR]) begin
                if (!aok(b_dst)) begin
                    st[ST_DST_BAD] = 1'b1; st[ST_WR_FAIL] = 1'b1;
                end else begin
                    for (int i = 0; i < nw && okf; i++) begin
                        a = b_dst + 32'(4 * i);
                        push_m(1'b1, a, 32'(i), {tag, " R6 write"});
                        if (a == err_addr) okf = 1'b0;
                    end
                    if (okf) st[ST_WR_OK] = 1'b1; else st[ST_WR_FAIL] = 1'b1;
                end
            end else begin
                if (!aok(b_src) || !aok(b_dst)) begin
                    st[ST_SRC_BAD] = !aok(b_src);
                    st[ST_DST_BAD] = !aok(b_dst);
                    st[ST_CP_FAIL] = 1'b1;
                end else begin
                    for (int i = 0; i < nw && okf; i++) begin
                        a = b_src + 32'(4 * i);
                        push_m(1'b0, a, 0, {tag, " R7 copy read"});
                        if (a == err_addr) begin
                            okf = 1'b0;
                        end else begin
                            w = mem[widx(a)];
                            a = b_dst + 32'(4 * i);
                            push_m(1'b1, a, w, {tag, " R7 copy write"});
                            if (a == err_addr) okf = 1'b0;
                        end
                    end
                    if (okf) st[ST_CP_OK] = 1'b1; else st[ST_CP_FAIL] = 1'b1;
                end
            end
            if (legal(b_kind, b_num)) begin
                push_i(b_kind, b_num, {tag, " R10 completion"});
                st[ST_IRQ] = 1'b1;
            end
        end

        reg_wr(RG_CMD, {26'b0, cmd});
        if (poke) begin
            reg_wr(RG_CMD, 32'h8);
            reg_rd(RG_CMD, v);
            check(v == {26'b0, cmd}, {tag, " R2 busy write ignored"}, v, {26'b0, cmd});
        end
        for (int t = 0; t < 4000 && !done; t++) begin
            reg_rd(RG_CMD, v);
            if (v == 0) done = 1'b1;
        end
        check(done, {tag, " R2 command self-clears"}, v, 32'h0);
        repeat (2) @(negedge clk);
        reg_rd(RG_STAT, v);
        check(v == st, {tag, " status"}, v, st);
        if (cmd[CB_RD]) begin
            reg_rd(RG_SUM, v);
            check(v == sum, {tag, " R5 checksum"}, v, sum);
        end
        check(mq.size() == 0, {tag, " R11 missing memory requests"}, 32'(mq.size()), 32'h0);
        check(iq.size() == 0, {tag, " R4 missing interrupts"}, 32'(iq.size()), 32'h0);
        mq.delete();
        iq.delete();
    endtask

    initial begin
        bit [31:0] v, v0;
        for (int i = 0; i < 256; i++) mem[i] = (32'(i) * 32'h9E37_79B9) ^ 32'h0F0F_00A5;
        rst = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state
        reg_rd(RG_STAT, v);    check(v == 0, "R2 status after reset", v, 0);
        reg_rd(RG_CMD, v);     check(v == 0, "R2 command after reset", v, 0);
        reg_rd(RG_SCRATCH, v); check(v == 0, "R1 scratch after reset", v, 0);
        check(mem_req == 1'b0 && irq_valid == 1'b0, "R11 idle outputs after reset",
              {31'b0, mem_req | irq_valid}, 0);

        // R1 scratch word
        reg_wr(RG_SCRATCH, 32'hA5C3_1E78); reg_rd(RG_SCRATCH, v);
        check(v == 32'hA5C3_1E78, "R1 scratch readback", v, 32'hA5C3_1E78);
        reg_wr(RG_SCRATCH, 32'h0000_FFFF); reg_rd(RG_SCRATCH, v);
        check(v == 32'h0000_FFFF, "R1 scratch second pattern", v, 32'h0000_FFFF);

        // R3 / R4 explicit raises and vector ranges
        set_cfg(32'h100, 32'h200, 32'd0, 1, 32'd5);
        run_op(6'h01, "R4 legacy with nonzero number", 1'b0);
        set_cfg(32'h100, 32'h200, 32'd0, 1, 32'd0);
        run_op(6'h01, "R3 legacy raise", 1'b0);
        set_cfg(32'h100, 32'h200, 32'd0, 0, 32'd32);
        run_op(6'h02, "R3 MSI upper edge", 1'b0);
        set_cfg(32'h100, 32'h200, 32'd0, 0, 32'd33);
        run_op(6'h02, "R4 MSI over range", 1'b0);
        set_cfg(32'h100, 32'h200, 32'd0, 0, 32'd2048);
        run_op(6'h04, "R3 MSI-X upper edge", 1'b0);
        set_cfg(32'h100, 32'h200, 32'd0, 0, 32'd2049);
        run_op(6'h04, "R4 MSI-X over range", 1'b0);
        set_cfg(32'h100, 32'h200, 32'd0, 0, 32'd0);
        run_op(6'h04, "R4 MSI-X zero", 1'b0);

        // R5 R6 R7 transfers with completion interrupts
        set_cfg(32'h100, 32'h200, 32'd16, 1, 32'd3);
        run_op(6'h08, "R5 read four words", 1'b0);
        set_cfg(32'h100, 32'h200, 32'd12, 2, 32'd700);
        run_op(6'h10, "R6 write three words", 1'b0);
        set_cfg(32'h100, 32'h300, 32'd16, 0, 32'd0);
        run_op(6'h20, "R7 copy with busy write", 1'b1);
        set_cfg(32'h140, 32'h200, 32'd0, 1, 32'd1);
        run_op(6'h08, "R7 zero count read", 1'b0);
        set_cfg(32'h140, 32'h200, 32'd6, 1, 32'd1);
        run_op(6'h08, "R5 count rounded down", 1'b0);

        // R8 invalid addresses
        set_cfg(32'h102, 32'h200, 32'd8, 1, 32'd2);
        run_op(6'h08, "R8 misaligned source", 1'b0);
        set_cfg(32'h100, 32'h0, 32'd8, 1, 32'd2);
        run_op(6'h10, "R8 zero destination", 1'b0);
        set_cfg(32'h0, 32'h301, 32'd8, 1, 32'd2);
        run_op(6'h20, "R8 both copy addresses bad", 1'b0);

        // R9 error responses
        err_addr = 32'h108;
        set_cfg(32'h100, 32'h200, 32'd16, 1, 32'd4);
        run_op(6'h08, "R9 read error", 1'b0);
        err_addr = 32'h308;
        set_cfg(32'h100, 32'h300, 32'd16, 1, 32'd4);
        run_op(6'h20, "R9 copy write error", 1'b0);
        err_addr = 32'hFFFF_FFF0;

        // R4 completion with reserved kind
        set_cfg(32'h100, 32'h200, 32'd4, 3, 32'd1);
        run_op(6'h08, "R4 reserved kind completion", 1'b0);

        // R2 non-one-hot command ignored
        reg_rd(RG_STAT, v0);
        reg_wr(RG_CMD, 32'h0000_0018);
        repeat (6) @(negedge clk);
        reg_rd(RG_CMD, v);
        check(v == 0, "R2 two-bit command not taken", v, 0);
        reg_rd(RG_STAT, v);
        check(v == v0, "R2 status kept after rejected command", v, v0);
        reg_wr(RG_CMD, 32'h0);
        repeat (4) @(negedge clk);
        reg_rd(RG_STAT, v);
        check(v == v0, "R2 zero command not taken", v, v0);

        report_and_end();
    end
endmodule